// File: doc/BRIEF.md
# Program Counter and Return-Stack Sequencer

This block produces the instruction fetch address for a small 8-bit controller whose program space is 1K words. The instruction decoder issues one operation code each cycle, and the sequencer moves to its next address from that code. The address can advance by one, load a branch target, enter a subroutine or the interrupt handler, return from either, or be changed by arithmetic on its low byte using the accumulator value. A four-entry circular return stack holds the return addresses. When too many entries are pushed or too many are popped, sticky error flags are set.

The sequencer also has a one-entry shadow store that holds the accumulator and the ALU flags across an interrupt handler. It latches a two-bit reset-cause code while reset is held. That code always appears in the top two bits of the restored flag byte and never comes from the shadow store. The ROM, the decoder and the ALU are outside this block.

Top module: `pcSequencer`

## Requirements
- R1: While `rstN` is low the fetch address is 0x000, the stack depth is 0, and `stackOvf`, `stackUnf`, `gieSet` and `restoreStrobe` are low. `resetFlags` latches from `rstCause`: 0 (power-on) and 3 give 2'b10, 1 (watchdog) gives 2'b00, 2 (external pin) gives 2'b11.
- R2: Op 0 (step) adds one to the 10-bit fetch address, and 0x3FF wraps to 0x000.
- R3: Op 1 (jump) loads `target`. Op 2 (call) pushes the fetch address plus one and loads `target`.
- R4: Op 3 (return) on a non-empty stack loads the most recently pushed address and lowers the depth by one.
- R5: Op 5 (interrupt entry) pushes the current fetch address unchanged and loads 0x008. Op 4 (return from interrupt) pops like op 3 and drives `gieSet` high for exactly the next cycle.
- R6: The stack holds four entries. A push while four are held overwrites the oldest entry, keeps the depth at 4 and sets the sticky `stackOvf`.
- R7: Op 3 or 4 with an empty stack adds one to the fetch address, leaves the depth at 0 and sets the sticky `stackUnf`.
- R8: Op 6 replaces the low address byte with (low byte + `accIn`) mod 256, and a carry out increments the upper two bits mod 4.
- R9: Op 7 replaces the low byte with (low byte − `accIn`) mod 256 and never changes the upper two bits.
- R10: Op 8 loads the low byte from `accIn` at any address, including 0x?FE and 0x?FF, and leaves the upper two bits unchanged.
- R11: Op 9 (save) captures `accIn` and `aluFlags`. Op 10 (restore) raises `restoreStrobe` for the next cycle. `restAcc` returns the saved accumulator. `restFlags[5:0]` returns the saved flags and `restFlags[7:6]` shows the live `resetFlags`. Both ops add one to the fetch address.
- R12: Op codes 11 to 15 hold the fetch address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| rstCause | input | 2 | Reset cause code, latched while rstN is low |
| op | input | 4 | Decoded operation code |
| target | input | 10 | Jump or call destination |
| accIn | input | 8 | Accumulator value |
| aluFlags | input | 6 | ALU flag bits for the save operation |
| fetchAddr | output | 10 | Current fetch address |
| stackDepth | output | 3 | Number of valid return entries |
| stackOvf | output | 1 | Sticky push-overflow flag |
| stackUnf | output | 1 | Sticky pop-underflow flag |
| gieSet | output | 1 | One-cycle global interrupt enable pulse |
| restoreStrobe | output | 1 | One-cycle restore pulse |
| restAcc | output | 8 | Restored accumulator |
| restFlags | output | 8 | Restored flags, with the reset cause in bits 7:6 |
| resetFlags | output | 2 | Latched reset cause flags |

## Verification
The properties assume that `op` is stable and known at every rising edge after reset, and that any reset pulse lasts at least one edge. The bench drives every input one time unit after an edge and holds it through the next edge. The sweeps use fixed sets of addresses and accumulator values that include page ends, the 0x3FF wrap and carry or borrow across the low byte. The stack tests use call chains whose pushed values are known in advance, so the expected pop order comes from simple arithmetic.

// File: rtl/pcSeqPkg.sv
package pcSeqPkg;
  typedef enum logic [3:0] {
    OP_STEP    = 4'd0,
    OP_JUMP    = 4'd1,
    OP_CALL    = 4'd2,
    OP_RET     = 4'd3,
    OP_RETI    = 4'd4,
    OP_IRQ     = 4'd5,
    OP_ADDL    = 4'd6,
    OP_SUBL    = 4'd7,
    OP_WRL     = 4'd8,
    OP_SAVE    = 4'd9,
    OP_RESTORE = 4'd10,
    OP_HOLD    = 4'd11
  } seqOp_e;

  typedef enum logic [2:0] {
    SEL_HOLD, SEL_INC, SEL_TARGET, SEL_POP,
    SEL_VEC, SEL_ADD, SEL_SUB, SEL_WRL
  } pcSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   pushEn;
    logic   pushCur;   // push current address instead of address + 1
    logic   saveEn;
  } seqStrobe_t;
endpackage

// File: rtl/pcSeqCtrl.sv
module pcSeqCtrl
  import pcSeqPkg::*;
#(
  parameter int DEPTH = 4,
  localparam int SP_W  = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       op,
  input  logic [1:0]       rstCause,
  output seqStrobe_t       strobe,
  output logic [SP_W-1:0]  wrIdx,
  output logic [SP_W-1:0]  rdIdx,
  output logic [CNT_W-1:0] depthQ,
  output logic             ovfQ,
  output logic             unfQ,
  output logic             gieQ,
  output logic             restoreQ,
  output logic [1:0]       causeQ
);
  seqOp_e          opE;
  logic [SP_W-1:0] topPtr;
  logic            doPop;
  logic            isReturn;
  logic            stackFull;
  logic            stackEmpty;

  assign opE        = seqOp_e'(op);
  assign wrIdx      = topPtr + SP_W'(1);
  assign rdIdx      = topPtr;
  assign stackFull  = (depthQ == CNT_W'(DEPTH));
  assign stackEmpty = (depthQ == '0);
  assign isReturn   = (opE == OP_RET) || (opE == OP_RETI);

  always_comb begin
    strobe = '{pcSel: SEL_HOLD, pushEn: 1'b0, pushCur: 1'b0, saveEn: 1'b0};
    doPop  = 1'b0;
    case (opE)
      OP_STEP:    strobe.pcSel = SEL_INC;
      OP_JUMP:    strobe.pcSel = SEL_TARGET;
      OP_CALL: begin
        strobe.pcSel  = SEL_TARGET;
        strobe.pushEn = 1'b1;
      end
      OP_RET, OP_RETI: begin
        if (stackEmpty) strobe.pcSel = SEL_INC;
        else begin
          strobe.pcSel = SEL_POP;
          doPop        = 1'b1;
        end
      end
      OP_IRQ: begin
        strobe.pcSel   = SEL_VEC;
        strobe.pushEn  = 1'b1;
        strobe.pushCur = 1'b1;
      end
      OP_ADDL:    strobe.pcSel = SEL_ADD;
      OP_SUBL:    strobe.pcSel = SEL_SUB;
      OP_WRL:     strobe.pcSel = SEL_WRL;
      OP_SAVE: begin
        strobe.pcSel  = SEL_INC;
        strobe.saveEn = 1'b1;
      end
      OP_RESTORE: strobe.pcSel = SEL_INC;
      default:    strobe.pcSel = SEL_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topPtr   <= '0;
      depthQ   <= '0;
      ovfQ     <= 1'b0;
      unfQ     <= 1'b0;
      gieQ     <= 1'b0;
      restoreQ <= 1'b0;
      case (rstCause)
        2'd1:    causeQ <= 2'b00;
        2'd2:    causeQ <= 2'b11;
        default: causeQ <= 2'b10;
      endcase
    end else begin
      gieQ     <= (opE == OP_RETI);
      restoreQ <= (opE == OP_RESTORE);
      if (strobe.pushEn) begin
        topPtr <= wrIdx;
        if (stackFull) ovfQ <= 1'b1;
        else           depthQ <= depthQ + CNT_W'(1);
      end
      if (doPop) begin
        topPtr <= topPtr - SP_W'(1);
        depthQ <= depthQ - CNT_W'(1);
      end
      if (isReturn && stackEmpty) unfQ <= 1'b1;
    end
  end
endmodule

// File: rtl/pcSeqPath.sv
module pcSeqPath
  import pcSeqPkg::*;
#(
  parameter int PC_W    = 10,
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 8,
  parameter int FLAG_W  = 6,
  parameter int IRQ_VEC = 8,
  localparam int SP_W   = $clog2(DEPTH),
  localparam int HI_W   = PC_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [SP_W-1:0]   wrIdx,
  input  logic [SP_W-1:0]   rdIdx,
  input  logic [PC_W-1:0]   target,
  input  logic [DATA_W-1:0] accIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [PC_W-1:0]   pcQ,
  output logic [DATA_W-1:0] shadowAcc,
  output logic [FLAG_W-1:0] shadowFlags
);
  logic [PC_W-1:0]   stackMem [DEPTH];
  logic [PC_W-1:0]   pcNext;
  logic [PC_W-1:0]   pcInc;
  logic [PC_W-1:0]   pushVal;
  logic [HI_W-1:0]   hiPart;
  logic [DATA_W:0]   lowSum;
  logic [DATA_W-1:0] lowDiff;

  assign pcInc   = pcQ + PC_W'(1);
  assign pushVal = strobe.pushCur ? pcQ : pcInc;
  assign hiPart  = pcQ[PC_W-1:DATA_W];
  assign lowSum  = {1'b0, pcQ[DATA_W-1:0]} + {1'b0, accIn};
  assign lowDiff = pcQ[DATA_W-1:0] - accIn;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobe.pushEn && (wrIdx == SP_W'(g))) stackMem[g] <= pushVal;
    end
  end

  always_comb begin
    case (strobe.pcSel)
      SEL_INC:    pcNext = pcInc;
      SEL_TARGET: pcNext = target;
      SEL_POP:    pcNext = stackMem[rdIdx];
      SEL_VEC:    pcNext = PC_W'(IRQ_VEC);
      SEL_ADD:    pcNext = {hiPart + HI_W'(lowSum[DATA_W]), lowSum[DATA_W-1:0]};
      SEL_SUB:    pcNext = {hiPart, lowDiff};
      SEL_WRL:    pcNext = {hiPart, accIn};
      default:    pcNext = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ         <= '0;
      shadowAcc   <= '0;
      shadowFlags <= '0;
    end else begin
      pcQ <= pcNext;
      if (strobe.saveEn) begin
        shadowAcc   <= accIn;
        shadowFlags <= flagsIn;
      end
    end
  end
endmodule

// File: rtl/pcSequencer.sv
module pcSequencer
  import pcSeqPkg::*;
#(
  parameter int PC_W    = 10,
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 8,
  parameter int IRQ_VEC = 8,
  localparam int FLAG_W = DATA_W - 2,
  localparam int SP_W   = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        rstCause,
  input  logic [3:0]        op,
  input  logic [PC_W-1:0]   target,
  input  logic [DATA_W-1:0] accIn,
  input  logic [FLAG_W-1:0] aluFlags,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [CNT_W-1:0]  stackDepth,
  output logic              stackOvf,
  output logic              stackUnf,
  output logic              gieSet,
  output logic              restoreStrobe,
  output logic [DATA_W-1:0] restAcc,
  output logic [DATA_W-1:0] restFlags,
  output logic [1:0]        resetFlags
);
  seqStrobe_t        strobe;
  logic [SP_W-1:0]   wrIdx;
  logic [SP_W-1:0]   rdIdx;
  logic [FLAG_W-1:0] shadowFlags;

  pcSeqCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .op(op), .rstCause(rstCause),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .depthQ(stackDepth), .ovfQ(stackOvf), .unfQ(stackUnf),
    .gieQ(gieSet), .restoreQ(restoreStrobe), .causeQ(resetFlags)
  );

  pcSeqPath #(
    .PC_W(PC_W), .DEPTH(DEPTH), .DATA_W(DATA_W),
    .FLAG_W(FLAG_W), .IRQ_VEC(IRQ_VEC)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .target(target), .accIn(accIn), .flagsIn(aluFlags),
    .pcQ(fetchAddr), .shadowAcc(restAcc), .shadowFlags(shadowFlags)
  );

  // reset-cause bits sit above the saved flags and always show live state
  assign restFlags = {resetFlags, shadowFlags};
endmodule

// File: rtl/pcSeqChecker.sv
module pcSeqChecker #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       op,
  input logic [PC_W-1:0]  fetchAddr,
  input logic [CNT_W-1:0] stackDepth,
  input logic             stackOvf,
  input logic             stackUnf,
  input logic             gieSet
);
  p_reset_vector_r1: assert property (@(posedge clk)
    !rstN |=> (fetchAddr == '0) && (stackDepth == '0));

  p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (op == 4'd0) |=> fetchAddr == PC_W'($past(fetchAddr) + PC_W'(1)));

  p_irq_vector_r5: assert property (@(posedge clk) disable iff (!rstN)
    (op == 4'd5) |=> fetchAddr == PC_W'(8));

  p_reti_gie_r5: assert property (@(posedge clk) disable iff (!rstN)
    (op == 4'd4) |=> gieSet);

  p_depth_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= CNT_W'(DEPTH));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    stackOvf |=> stackOvf);

  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    stackUnf |=> stackUnf);

  p_sub_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (op == 4'd7) |=> fetchAddr[PC_W-1:8] == $past(fetchAddr[PC_W-1:8]));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (op >= 4'd11) |=> $stable(fetchAddr));
endmodule

bind pcSequencer pcSeqChecker #(.PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .op(op), .fetchAddr(fetchAddr),
  .stackDepth(stackDepth), .stackOvf(stackOvf), .stackUnf(stackUnf),
  .gieSet(gieSet)
);

// File: tb/sim_pcSequencer.sv
`timescale 1ns/1ps
module sim_pcSequencer;
  localparam int STEP = 0, JUMP = 1, CALL = 2, RET = 3, RETI = 4, IRQ = 5;
  localparam int ADDL = 6, SUBL = 7, WRL = 8, SAVE = 9, RESTORE = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rstCause = 2'd0;
  logic [3:0] op = 4'd11;
  logic [9:0] target = '0;
  logic [7:0] accIn = '0;
  logic [5:0] aluFlags = '0;
  logic [9:0] fetchAddr;
  logic [2:0] stackDepth;
  logic       stackOvf, stackUnf, gieSet, restoreStrobe;
  logic [7:0] restAcc, restFlags;
  logic [1:0] resetFlags;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pcSequencer u0 (
    .clk(clk), .rstN(rstN), .rstCause(rstCause), .op(op), .target(target),
    .accIn(accIn), .aluFlags(aluFlags), .fetchAddr(fetchAddr),
    .stackDepth(stackDepth), .stackOvf(stackOvf), .stackUnf(stackUnf),
    .gieSet(gieSet), .restoreStrobe(restoreStrobe), .restAcc(restAcc),
    .restFlags(restFlags), .resetFlags(resetFlags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doOp(input int o, input int tgt = 0, input int acc = 0, input int fl = 0);
    op = 4'(o); target = 10'(tgt); accIn = 8'(acc); aluFlags = 6'(fl);
    @(posedge clk); #1;
  endtask

  task automatic doReset(input int cause);
    rstN = 1'b0; rstCause = 2'(cause); op = 4'd11;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  initial begin
    #1;
    // R1: reset state and cause encoding
    for (int c = 0; c < 4; c++) begin
      doReset(c);
      chk("R1 addr", fetchAddr, 0);
      chk("R1 depth", stackDepth, 0);
      chk("R1 sticky", {stackOvf, stackUnf, gieSet, restoreStrobe}, 0);
      chk("R1 cause", resetFlags, (c == 1) ? 0 : (c == 2) ? 3 : 2);
    end

    // R2: step with wrap
    doOp(JUMP, 10'h3F0);
    chk("R3 jump", fetchAddr, 10'h3F0);
    for (int i = 1; i <= 24; i++) begin
      doOp(STEP);
      chk("R2 step", fetchAddr, (10'h3F0 + i) & 10'h3FF);
    end

    // R8, R9, R10: low-byte arithmetic sweep
    for (int b = 0; b < 8; b++) begin
      int base;
      case (b)
        0: base = 10'h000; 1: base = 10'h0FE; 2: base = 10'h0FF; 3: base = 10'h180;
        4: base = 10'h2FF; 5: base = 10'h3C5; 6: base = 10'h3FE; default: base = 10'h155;
      endcase
      for (int a = 0; a < 256; a += 15) begin
        doOp(JUMP, base);
        doOp(ADDL, 0, a);
        chk("R8 add", fetchAddr, (base + a) & 10'h3FF);
        doOp(JUMP, base);
        doOp(SUBL, 0, a);
        chk("R9 sub", fetchAddr, (base & 10'h300) | ((base - a) & 8'hFF));
        doOp(JUMP, base);
        doOp(WRL, 0, a);
        chk("R10 wrl", fetchAddr, (base & 10'h300) | a);
      end
    end

    // R3, R4, R6, R7: call chain past capacity then drain
    doReset(0);
    for (int k = 1; k <= 5; k++) begin
      doOp(CALL, k * 16);
      chk("R3 call", fetchAddr, k * 16);
      chk("R6 depth", stackDepth, (k > 4) ? 4 : k);
      chk("R6 ovf", stackOvf, (k > 4) ? 1 : 0);
    end
    for (int k = 4; k >= 1; k--) begin
      doOp(RET);
      chk("R4 ret", fetchAddr, k * 16 + 1);
      chk("R4 depth", stackDepth, k - 1);
    end
    chk("R6 ovf kept", stackOvf, 1);
    chk("R7 no unf yet", stackUnf, 0);
    doOp(RET);
    chk("R7 empty ret addr", fetchAddr, 10'h012);
    chk("R7 unf", stackUnf, 1);
    chk("R7 depth", stackDepth, 0);
    doOp(STEP);
    chk("R7 unf sticky", stackUnf, 1);

    // R5: interrupt entry and return
    doReset(0);
    doOp(JUMP, 10'h123);
    doOp(IRQ);
    chk("R5 vector", fetchAddr, 8);
    chk("R5 depth", stackDepth, 1);
    doOp(STEP);
    chk("R5 gie idle", gieSet, 0);
    doOp(RETI);
    chk("R5 reti addr", fetchAddr, 10'h123);
    chk("R5 gie pulse", gieSet, 1);
    doOp(STEP);
    chk("R5 gie one cycle", gieSet, 0);
    chk("R5 after", fetchAddr, 10'h124);

    // R11: save/restore with live cause bits
    doReset(1);
    doOp(JUMP, 10'h040);
    doOp(SAVE, 0, 8'h5A, 6'h3F);
    chk("R11 save step", fetchAddr, 10'h041);
    doOp(STEP, 0, 8'h00, 6'h00);
    chk("R11 no strobe", restoreStrobe, 0);
    doOp(RESTORE, 0, 8'hC3, 6'h15);
    chk("R11 restore step", fetchAddr, 10'h043);
    chk("R11 strobe", restoreStrobe, 1);
    chk("R11 acc", restAcc, 8'h5A);
    chk("R11 flags watchdog", restFlags, 8'h3F);
    doOp(STEP);
    chk("R11 strobe one cycle", restoreStrobe, 0);
    doReset(2);
    doOp(SAVE, 0, 8'hA5, 6'h00);
    doOp(RESTORE);
    chk("R11 flags external", restFlags, 8'hC0);
    chk("R11 acc2", restAcc, 8'hA5);

    // R12: hold codes
    doOp(JUMP, 10'h2AA);
    for (int h = 11; h < 16; h++) begin
      doOp(h);
      chk("R12 hold", fetchAddr, 10'h2AA);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule